// File: doc/BRIEF.md
# Receive Destination and Length Filter

This block sits on the receive byte path, in front of the frame buffer. For each incoming frame it decides whether to keep it or throw it away. It holds the first six bytes, which carry the destination address, in a small buffer. When the sixth byte arrives it classifies the destination as unicast, group (multicast) or broadcast, compares it with a programmed station address, and applies three independent discard enables. An accepted frame is replayed unchanged from the buffer and then streamed straight through. A rejected frame is absorbed without any output, and a one-cycle discard pulse is raised.

A byte counter runs against a programmed maximum length. A frame that grows past the maximum is cut: its last forwarded byte is the one at the maximum, and that byte carries both the end marker and an error flag. The rest of the frame is consumed silently. All configuration is captured when a frame's first byte is accepted, so software may rewrite it at any time.

Both byte streams use valid/ready. A beat moves on a clock edge where valid and ready are both high. The source must hold its data and markers stable while valid is high and ready is low. `in_ready` is high while the header is being collected or the frame is being absorbed. It is low while the held header is being replayed. During pass-through it follows `out_ready`, so back-pressure reaches upstream with no extra storage.

Top module: `rx_dst_filter`

## Requirements
- R1: An accepted frame is forwarded byte for byte with `out_first` on its first byte, `out_last` on its final byte and `out_err` low.
- R2: Wire byte i of the destination is compared with station octet i. Octets 0..3 are `cfg_sta_lo[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`. Octet 4 is `cfg_sta_hi[7:0]` and octet 5 is `cfg_sta_hi[15:8]`.
- R3: With `cfg_sta_hi[16]` set, a unicast frame (bit 0 of the first byte is 0) whose destination differs from the station address is discarded.
- R4: With `cfg_sta_hi[18]` set, a group frame (bit 0 of the first byte is 1, not all six bytes 0xFF) is discarded.
- R5: With `cfg_sta_hi[17]` set, a broadcast frame (six bytes of 0xFF) is discarded. Broadcast frames are never discarded by the bit-16 or bit-18 enables.
- R6: With all three enables clear, every frame of at least six bytes within the maximum length is accepted.
- R7: A discarded frame produces no output beat. It produces exactly one high cycle of `drop_pulse`, registered on the edge after the deciding byte is transferred.
- R8: A frame that ends before its sixth byte is discarded with one `drop_pulse`.
- R9: A frame of at most `cfg_max_len` bytes is not affected by the length check. A longer frame is forwarded as exactly `cfg_max_len` bytes, the last of which carries both `out_last` and `out_err`, and raises no `drop_pulse`. A maximum below 6 discards every frame as in R7.
- R10: The configuration inputs are sampled when a frame's first byte is accepted. Changes made later in that frame do not affect it.
- R11: While `out_valid` is high and `out_ready` is low, the output beat stays unchanged. No byte is lost or repeated under any pattern of back-pressure.
- R12: Bytes that arrive between frames without `in_first` are absorbed without output and without `drop_pulse`.
- R13: During and after reset, `out_valid` and `drop_pulse` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Input byte is the first of a frame |
| in_last | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | Output byte starts a frame |
| out_last | output | 1 | Output byte ends a frame |
| out_err | output | 1 | Frame was cut at the maximum length |
| drop_pulse | output | 1 | One cycle per discarded frame |
| cfg_sta_lo | input | 32 | Station octets 0..3 |
| cfg_sta_hi | input | 32 | Station octets 4..5 in [15:0]; discard enables: [16] mismatch, [17] broadcast, [18] group |
| cfg_max_len | input | LEN_W | Maximum frame length in bytes |

## Verification
The bench sweeps every combination of the three enables against matching, mismatching, group and broadcast destinations. It also flips each destination byte in turn. A design that swapped octets, or treated broadcast as an ordinary group address, would then drop or pass the wrong frames. Frame lengths are swept across the runt boundary and across a small maximum, and the maximum itself is swept from below six up past the frame length. This catches off-by-one cuts, a missing error flag, and a stray discard pulse on cut frames. The whole sweep is run again with random output stalls, which exposes a replay that skips or repeats a held byte. Configuration changed in the middle of a frame, and stray bytes between frames, must leave the output untouched.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int HDR_BYTES = 6;
  localparam int IDX_W     = 3;
  localparam int EN_MISMATCH_BIT = 16;
  localparam int EN_BCAST_BIT    = 17;
  localparam int EN_GROUP_BIT    = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_FLUSH,
    ST_PASS,
    ST_SINK
  } rxf_state_e;

  typedef struct packed {
    logic [8*HDR_BYTES-1:0] sta;
    logic                   en_mismatch;
    logic                   en_bcast;
    logic                   en_group;
  } rxf_cfg_t;
endpackage

// File: rtl/rxf_cfg_snap.sv
module rxf_cfg_snap
  import rxf_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [31:0]      sta_lo,
  input  logic [31:0]      sta_hi,
  input  logic [LEN_W-1:0] max_len,
  output rxf_cfg_t         snap,
  output logic [LEN_W-1:0] snap_max
);
  localparam logic [LEN_W-1:0] MAX_RST = {LEN_W{1'b1}} - LEN_W'(3);

  logic unused_hi;
  assign unused_hi = ^sta_hi[31:19];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap     <= '0;
      snap_max <= MAX_RST;
    end else if (take) begin
      snap.sta         <= {sta_hi[15:0], sta_lo};
      snap.en_mismatch <= sta_hi[EN_MISMATCH_BIT];
      snap.en_bcast    <= sta_hi[EN_BCAST_BIT];
      snap.en_group    <= sta_hi[EN_GROUP_BIT];
      snap_max         <= max_len;
    end
  end
endmodule

// File: rtl/rxf_hdr_buf.sv
module rxf_hdr_buf #(
  parameter int NBYTES = 6,
  parameter int IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [8*NBYTES-1:0]   bytes
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes[8*g +: 8] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        bytes[8*g +: 8] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic [8*HDR_BYTES-1:0] dst,
  input  rxf_cfg_t               cfg,
  input  logic [LEN_W-1:0]       max_len,
  output logic                   reject
);
  logic [HDR_BYTES-1:0] eq;
  logic [HDR_BYTES-1:0] all_ones;

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_cmp
    assign eq[g]       = (dst[8*g +: 8] == cfg.sta[8*g +: 8]);
    assign all_ones[g] = &dst[8*g +: 8];
  end

  logic hit, is_bcast, is_group, is_ucast, too_short_max;

  always_comb begin
    hit           = &eq;
    is_bcast      = &all_ones;
    is_group      = dst[0] & ~is_bcast;
    is_ucast      = ~dst[0];
    too_short_max = (max_len < LEN_W'(HDR_BYTES));
    reject = too_short_max
           | (is_bcast & cfg.en_bcast)
           | (is_group & cfg.en_group)
           | (is_ucast & ~hit & cfg.en_mismatch);
  end
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             out_last,
  output logic             out_err,
  output logic             drop_pulse,
  input  logic [31:0]      cfg_sta_lo,
  input  logic [31:0]      cfg_sta_hi,
  input  logic [LEN_W-1:0] cfg_max_len
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] HDR_LEN  = LEN_W'(HDR_BYTES);

  rxf_state_e       st_q, st_d;
  logic [LEN_W-1:0] len_q, len_d, len_nx;
  logic [IDX_W-1:0] fl_idx_q, fl_idx_d;
  logic             fl_last_q, fl_last_d;
  logic             fl_err_q, fl_err_d;
  rxf_state_e       fl_next_q, fl_next_d;
  logic             drop_d;

  logic in_fire, out_fire, take, buf_wr, reject, cut_hdr;
  rxf_cfg_t               snap;
  logic [LEN_W-1:0]       snap_max;
  logic [8*HDR_BYTES-1:0] hdr_vec;
  logic [8*HDR_BYTES-1:0] dst_vec;
  logic [IDX_W-1:0]       wr_idx;

  assign in_fire  = in_valid & in_ready;
  assign out_fire = out_valid & out_ready;
  assign take     = (st_q == ST_IDLE) & in_fire & in_first;
  assign buf_wr   = take | ((st_q == ST_HDR) & in_fire);
  assign wr_idx   = (st_q == ST_IDLE) ? '0 : len_q[IDX_W-1:0];
  assign len_nx   = len_q + LEN_W'(1);
  assign dst_vec  = {in_data, hdr_vec[8*(HDR_BYTES-1)-1:0]};
  assign cut_hdr  = (snap_max == HDR_LEN);

  rxf_cfg_snap #(.LEN_W(LEN_W)) snap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .sta_lo   (cfg_sta_lo),
    .sta_hi   (cfg_sta_hi),
    .max_len  (cfg_max_len),
    .snap     (snap),
    .snap_max (snap_max)
  );

  rxf_hdr_buf #(.NBYTES(HDR_BYTES), .IDX_W(IDX_W)) hdr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_wr),
    .wr_idx  (wr_idx),
    .wr_data (in_data),
    .bytes   (hdr_vec)
  );

  rxf_classify #(.LEN_W(LEN_W)) cls_i (
    .dst     (dst_vec),
    .cfg     (snap),
    .max_len (snap_max),
    .reject  (reject)
  );

  // Stream handshake and output mux
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_first = 1'b0;
    out_last  = 1'b0;
    out_err   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_HDR, ST_SINK: in_ready = 1'b1;
      ST_FLUSH: begin
        out_valid = 1'b1;
        out_data  = hdr_vec[8*fl_idx_q +: 8];
        out_first = (fl_idx_q == '0);
        out_last  = (fl_idx_q == LAST_IDX) & fl_last_q;
        out_err   = (fl_idx_q == LAST_IDX) & fl_err_q;
      end
      ST_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last | (len_nx == snap_max);
        out_err   = ~in_last & (len_nx == snap_max);
      end
      default: ;
    endcase
  end

  // Frame sequencing
  always_comb begin
    st_d      = st_q;
    len_d     = len_q;
    fl_idx_d  = fl_idx_q;
    fl_last_d = fl_last_q;
    fl_err_d  = fl_err_q;
    fl_next_d = fl_next_q;
    drop_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_fire && in_first) begin
          len_d = LEN_W'(1);
          if (in_last) drop_d = 1'b1;
          else         st_d   = ST_HDR;
        end
      end
      ST_HDR: begin
        if (in_fire) begin
          len_d = len_nx;
          if (len_q == HDR_LEN - LEN_W'(1)) begin
            if (reject) begin
              drop_d = 1'b1;
              st_d   = in_last ? ST_IDLE : ST_SINK;
            end else begin
              fl_idx_d  = '0;
              fl_last_d = in_last | cut_hdr;
              fl_err_d  = ~in_last & cut_hdr;
              fl_next_d = in_last ? ST_IDLE : (cut_hdr ? ST_SINK : ST_PASS);
              st_d      = ST_FLUSH;
            end
          end else if (in_last) begin
            drop_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      ST_FLUSH: begin
        if (out_fire) begin
          if (fl_idx_q == LAST_IDX) st_d = fl_next_q;
          else fl_idx_d = fl_idx_q + IDX_W'(1);
        end
      end
      ST_PASS: begin
        if (in_fire) begin
          len_d = len_nx;
          if (in_last)                   st_d = ST_IDLE;
          else if (len_nx == snap_max)   st_d = ST_SINK;
        end
      end
      ST_SINK: begin
        if (in_fire && in_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      len_q      <= '0;
      fl_idx_q   <= '0;
      fl_last_q  <= 1'b0;
      fl_err_q   <= 1'b0;
      fl_next_q  <= ST_IDLE;
      drop_pulse <= 1'b0;
    end else begin
      st_q       <= st_d;
      len_q      <= len_d;
      fl_idx_q   <= fl_idx_d;
      fl_last_q  <= fl_last_d;
      fl_err_q   <= fl_err_d;
      fl_next_q  <= fl_next_d;
      drop_pulse <= drop_d;
    end
  end
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_first,
  input logic             out_last,
  input logic             out_err,
  input logic [LEN_W-1:0] snap_max
);
  logic [LEN_W:0] ocnt;
  logic           in_pkt;
  logic           beat;

  assign beat = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt   <= '0;
      in_pkt <= 1'b0;
    end else if (beat) begin
      ocnt   <= out_last ? '0 : ocnt + 1'b1;
      in_pkt <= ~out_last;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R11

  AST_ERR_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> out_last); // R9

  AST_FIRST_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (out_first == !in_pkt)); // R1

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> ((ocnt + 1'b1) <= {1'b0, snap_max})); // R9
endmodule

bind rx_dst_filter rxf_chk #(.LEN_W(LEN_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_first (out_first),
  .out_last  (out_last),
  .out_err   (out_err),
  .snap_max  (snap_max)
);

// File: tb/rx_dst_filter_tb_top.sv
module rx_dst_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic out_valid, out_first, out_last, out_err, drop_pulse;
  logic out_ready;
  logic [7:0] out_data;
  logic [31:0] cfg_sta_lo = 32'h33221102;
  logic [31:0] cfg_sta_hi = 32'h0000_5544;
  logic [LEN_W-1:0] cfg_max_len = LEN_W'(1500);

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dst_filter #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_err(out_err),
    .drop_pulse(drop_pulse),
    .cfg_sta_lo(cfg_sta_lo), .cfg_sta_hi(cfg_sta_hi), .cfg_max_len(cfg_max_len)
  );

  int checks = 0;
  int fails = 0;
  int drops = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr;
  string cur_req = "R1";

  logic [7:0] sta [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
  logic [7:0] fb [128];
  logic [10:0] exp_q [1024];
  int exp_wr = 0, exp_rd = 0;

  bit m_da, m_bc, m_mc;
  int m_max;

  // Output stall pattern
  always @(negedge clk) begin
    if (!rst_n) begin
      lfsr <= 16'hACE1;
      out_ready <= 1'b1;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // Output monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_rd >= exp_wr) begin
        fails++;
        $display("FAIL %s: unexpected beat data=%02h first=%0b last=%0b err=%0b, expected none",
                 cur_req, out_data, out_first, out_last, out_err);
      end else begin
        if ({out_data, out_first, out_last, out_err} !== exp_q[exp_rd]) begin
          fails++;
          $display("FAIL %s: beat %0d got {data,first,last,err}=%03h expected %03h",
                   cur_req, exp_rd, {out_data, out_first, out_last, out_err}, exp_q[exp_rd]);
        end
        exp_rd++;
      end
    end
    if (rst_n && drop_pulse) drops++;
  end

  task automatic set_cfg(input bit da, input bit bc, input bit mc, input int mx);
    cfg_sta_hi = {13'h0, mc, bc, da, 16'h5544};
    cfg_max_len = LEN_W'(mx);
  endtask

  // ty: 0 station, 1 station with one byte flipped, 2 group, 3 broadcast
  task automatic build(input int ty, input int len, input int seed, input int flip);
    for (int i = 0; i < 128; i++) fb[i] = 8'((i * 13 + seed) & 8'hFF);
    for (int i = 0; i < 6; i++) begin
      case (ty)
        0: fb[i] = sta[i];
        1: fb[i] = (i == flip) ? (sta[i] ^ 8'h10) : sta[i];
        2: fb[i] = (i == 0) ? 8'h01 : (i == 1) ? 8'h00 : (i == 2) ? 8'h5E : 8'(seed + i);
        default: fb[i] = 8'hFF;
      endcase
    end
    if (len < 128) fb[len] = fb[len];
  endtask

  // Expected result from the requirements; returns expected drop count
  function automatic int predict(input int len);
    bit bc, mc, uc, hit, rej;
    int n;
    m_da = cfg_sta_hi[16]; m_bc = cfg_sta_hi[17]; m_mc = cfg_sta_hi[18];
    m_max = int'(cfg_max_len);
    exp_wr = 0; exp_rd = 0;
    if (len < 6) return 1;
    bc = 1; hit = 1;
    for (int i = 0; i < 6; i++) begin
      if (fb[i] != 8'hFF) bc = 0;
      if (fb[i] != sta[i]) hit = 0;
    end
    mc = fb[0][0] && !bc;
    uc = !fb[0][0];
    rej = (m_max < 6) || (bc && m_bc) || (mc && m_mc) || (uc && !hit && m_da);
    if (rej) return 1;
    n = (len > m_max) ? m_max : len;
    for (int i = 0; i < n; i++) begin
      exp_q[exp_wr] = {fb[i], (i == 0), (i == n - 1), ((i == n - 1) && (len > m_max))};
      exp_wr++;
    end
    return 0;
  endfunction

  bit pend_da, pend_bc, pend_mc;

  task automatic send(input int len, input int chg_at);
    bit took;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == chg_at) set_cfg(pend_da, pend_bc, pend_mc, int'(cfg_max_len));
      in_valid = 1'b1;
      in_data  = fb[i];
      in_first = (i == 0);
      in_last  = (i == len - 1);
      forever begin
        #1 took = in_ready;
        @(posedge clk);
        if (took) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_case(input string req, input int len, input int chg_at);
    int exp_drop, d0, waitc;
    cur_req = req;
    exp_drop = predict(len);
    d0 = drops;
    send(len, chg_at);
    waitc = 0;
    while (exp_rd < exp_wr && waitc < 400) begin
      @(negedge clk); waitc++;
    end
    repeat (3) @(negedge clk);
    checks++;
    if ((drops - d0) != exp_drop || exp_rd != exp_wr) begin
      fails++;
      $display("FAIL %s: len=%0d drops=%0d beats=%0d, expected drops=%0d beats=%0d",
               req, len, drops - d0, exp_rd, exp_drop, exp_wr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++; // R13
    if (out_valid !== 1'b0 || drop_pulse !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R13: reset state valid=%0b drop=%0b ready=%0b expected 0 0 1",
               out_valid, drop_pulse, in_ready);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int bp = 0; bp < 2; bp++) begin
      bp_on = (bp == 1);
      // R3 R4 R5 R6: enables against destination kinds
      for (int en = 0; en < 8; en++) begin
        for (int ty = 0; ty < 4; ty++) begin
          for (int k = 0; k < 2; k++) begin
            string rq;
            set_cfg(en[0], en[1], en[2], 1500);
            build(ty, k ? 20 : 6, en * 4 + ty, 3);
            rq = (en == 0) ? "R6" : (ty == 0) ? "R1" : (ty == 1) ? "R3" :
                 (ty == 2) ? "R4" : "R5";
            run_case(rq, k ? 20 : 6, -1);
          end
        end
      end
      // R2: each destination byte position against its octet
      for (int p = 0; p < 6; p++) begin
        set_cfg(1, 0, 0, 1500);
        build(1, 10, p, p);
        run_case("R2", 10, -1);
      end
      // R8 and R9: length sweep around a small maximum
      for (int len = 1; len <= 26; len++) begin
        set_cfg(0, 0, 0, 20);
        build(0, len, len, 0);
        run_case(len < 6 ? "R8" : "R9", len, -1);
      end
      // R9 / R7: maximum swept through the header size
      for (int mx = 3; mx <= 9; mx++) begin
        for (int k = 0; k < 2; k++) begin
          set_cfg(0, 0, 0, mx);
          build(2, k ? 12 : 7, mx, 0);
          run_case(mx < 6 ? "R7" : "R9", k ? 12 : 7, -1);
        end
      end
    end
    bp_on = 1'b0;

    // R1: long frame at the top of the length range
    set_cfg(1, 1, 1, 16'h3FFF);
    build(0, 100, 9, 0);
    run_case("R1", 100, -1);

    // R10: configuration changed mid-frame
    set_cfg(0, 0, 0, 1500);
    build(1, 15, 1, 2);
    pend_da = 1; pend_bc = 0; pend_mc = 0;
    run_case("R10", 15, 3);
    build(1, 15, 2, 2);
    run_case("R10", 15, -1);
    pend_da = 0;
    build(1, 15, 3, 2);
    run_case("R10", 15, 3);

    // R12: stray bytes between frames
    set_cfg(0, 0, 0, 1500);
    cur_req = "R12";
    exp_wr = 0; exp_rd = 0;
    begin
      int d0;
      d0 = drops;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'(8'hA0 + i); in_first = 1'b0; in_last = (i == 2);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (4) @(negedge clk);
      checks++;
      if (drops != d0 || exp_rd != 0) begin
        fails++;
        $display("FAIL R12: stray bytes gave drops=%0d beats=%0d expected 0 0", drops - d0, exp_rd);
      end
    end
    build(0, 9, 5, 0);
    run_case("R12", 9, -1);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule